// File: doc/BRIEF.md
# USB OUT Endpoint Receive Controller

This block runs the receive side of one USB OUT endpoint. It holds a small command register, a byte FIFO and a receive sequencer. The sequencer watches token, data-byte and packet-end events from the USB receive engine. For each packet it decides whether the data goes into the FIFO or is dropped, and whether an ACK is requested. Firmware arms reception one packet at a time, drains the FIFO through a read port and can ask for the FIFO to be emptied.

OUT data is taken only while the arm bit is set, and that bit clears itself after every data packet. SETUP data is always taken unless firmware has chosen to ignore SETUP tokens. A SETUP that repeats an already-accepted SETUP, with no other token in between, is dropped but still acknowledged. A flush request that arrives during a packet waits until the packet ends. A programmable limit on free space produces a one-cycle warning event.

Top module: `usb_rx_ep_ctrl`

## Requirements
- R1: After reset the command register reads 0x00, the FIFO level is 0, and neither `hs_ack` nor `warn_pulse` is asserted.
- R2: The command register holds the arm bit at bit 0, the SETUP-ignore bit at bit 2, the flush bit at bit 3 and the 2-bit warning limit code at bits 6:5. The flush bit and bits 1, 4 and 7 always read 0, so writing 0xFF reads back 0x65.
- R3: With the arm bit set, an OUT packet's bytes are stored in arrival order. If the packet ends good, `hs_ack` pulses for exactly one cycle, in the cycle after the packet-end event. The arm bit reads 0 afterwards.
- R4: With the arm bit clear, OUT data is not stored and no ACK is requested.
- R5: An OUT token that arrives with `stall_in` high stores no data, requests no ACK and clears the arm bit.
- R6: SETUP data is stored and acknowledged whatever the state of the arm bit.
- R7: With the SETUP-ignore bit set, a SETUP packet stores nothing and requests no handshake, even directly after an accepted SETUP.
- R8: A SETUP that follows an accepted SETUP with no other token in between is dropped, leaving the FIFO level unchanged, and is still ACKed. After any non-SETUP token, the next SETUP is stored again.
- R9: A packet that ends with `rx_pkt_ok` low requests no ACK. Its already stored bytes stay in the FIFO.
- R10: The FIFO holds DEPTH (64) bytes. A byte arriving while the FIFO is full is lost and the packet is not ACKed.
- R11: Writing 1 to the flush bit empties the FIFO. If a packet is in progress, the FIFO keeps its contents until that packet has ended, and is emptied on the next cycle.
- R12: The warning limit code selects how much free space triggers the warning: 00 disables it, 01 = 4 bytes, 10 = 8 bytes, 11 = 16 bytes. `warn_pulse` is high for one cycle when the free space first falls to or below the selected limit.
- R13: The FIFO read port presents the oldest byte on `fifo_rd_data`, and a read strobe pops it and lowers `fifo_level` by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Command register write strobe |
| reg_wr_data | input | 8 | Command register write value |
| reg_rd_data | output | 8 | Command register read value |
| tok_valid | input | 1 | Token event for this endpoint |
| tok_kind | input | 2 | Token type: 00 OUT, 01 SETUP, other values any other token |
| stall_in | input | 1 | Stall policy answers this OUT token with STALL |
| rx_byte_valid | input | 1 | Data byte event |
| rx_byte | input | 8 | Data byte |
| rx_pkt_end | input | 1 | Packet-end event |
| rx_pkt_ok | input | 1 | Packet ended without media error |
| fifo_rd_en | input | 1 | FIFO pop strobe |
| fifo_rd_data | output | 8 | Oldest FIFO byte |
| fifo_level | output | 7 | Bytes held in the FIFO |
| hs_ack | output | 1 | One-cycle ACK handshake request |
| warn_pulse | output | 1 | One-cycle FIFO warning event |

## Verification
The sequencer is driven with OUT packets that are armed, unarmed, stalled and ended bad, and with SETUP packets that are fresh, repeated, separated by an OUT token and ignored. Comparing the ACK and the FIFO level across these cases separates "dropped with ACK" from "dropped silently" from "stored". The FIFO is filled past full, which shows the overrun behaviour, and is flushed both while idle and in the middle of a packet, which shows the deferral. For each of the four limit codes a 64-byte fill is made one byte at a time, and the bench checks that the warning fires only at the byte where the free space reaches 4, 8 or 16, or never for code 00.

// File: rtl/usb_rxep_pkg.sv
package usb_rxep_pkg;

  localparam int unsigned BIT_ARM   = 0;
  localparam int unsigned BIT_IGN   = 2;
  localparam int unsigned BIT_FLUSH = 3;
  localparam int unsigned BIT_WL_LO = 5;

  typedef enum logic [1:0] {
    TOK_OUT   = 2'b00,
    TOK_SETUP = 2'b01,
    TOK_OTHER = 2'b10
  } tok_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TAKE   = 2'd1,
    ST_DROPA  = 2'd2,
    ST_DROPS  = 2'd3
  } ep_state_e;

  function automatic int unsigned warn_room(input logic [1:0] code);
    case (code)
      2'b01:   return 4;
      2'b10:   return 8;
      2'b11:   return 16;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/usb_rxep_regs.sv
module usb_rxep_regs
  import usb_rxep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       arm_clr,
  input  logic       flush_done,
  output logic       arm,
  output logic       ign_setup,
  output logic [1:0] wl_code,
  output logic       flush_pend,
  output logic [7:0] rd_data
);

  logic       arm_q, arm_d;
  logic       ign_q, ign_d;
  logic [1:0] wl_q, wl_d;
  logic       fl_q, fl_d;

  always_comb begin
    arm_d = arm_q;
    ign_d = ign_q;
    wl_d  = wl_q;
    fl_d  = fl_q;
    if (arm_clr)    arm_d = 1'b0;
    if (flush_done) fl_d  = 1'b0;
    if (wr_en) begin
      arm_d = wr_data[BIT_ARM];
      ign_d = wr_data[BIT_IGN];
      wl_d  = wr_data[BIT_WL_LO +: 2];
      if (wr_data[BIT_FLUSH]) fl_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      ign_q <= 1'b0;
      wl_q  <= 2'b00;
      fl_q  <= 1'b0;
    end else begin
      arm_q <= arm_d;
      ign_q <= ign_d;
      wl_q  <= wl_d;
      fl_q  <= fl_d;
    end
  end

  always_comb begin
    rd_data                   = 8'h00;
    rd_data[BIT_ARM]          = arm_q;
    rd_data[BIT_IGN]          = ign_q;
    rd_data[BIT_WL_LO +: 2]   = wl_q;
  end

  assign arm        = arm_q;
  assign ign_setup  = ign_q;
  assign wl_code    = wl_q;
  assign flush_pend = fl_q;

endmodule

// File: rtl/usb_rxep_fifo.sv
module usb_rxep_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [LW-1:0] level,
  output logic          full
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          wr_ok, rd_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full  = (cnt_q == LW'(DEPTH));
  assign wr_ok = wr_en && !full && !flush;
  assign rd_ok = rd_en && (cnt_q != '0) && !flush;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (wr_ok) wp_d = bump(wp_q);
      if (rd_ok) rp_d = bump(rp_q);
      cnt_d = cnt_q + LW'(wr_ok) - LW'(rd_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= wr_data;
  end

  assign rd_data = mem[rp_q];
  assign level   = cnt_q;

endmodule

// File: rtl/usb_rxep_seq.sv
module usb_rxep_seq
  import usb_rxep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_valid,
  input  logic [1:0] tok_kind,
  input  logic       stall_in,
  input  logic       byte_valid,
  input  logic       pkt_end,
  input  logic       pkt_ok,
  input  logic       arm,
  input  logic       ign_setup,
  input  logic       fifo_full,
  input  logic       flush_pend,
  output logic       fifo_wr,
  output logic       arm_clr,
  output logic       flush_go,
  output logic       idle,
  output logic       ack
);

  ep_state_e st_q, st_d;
  logic      seen_q, seen_d;
  logic      setup_q, setup_d;
  logic      ovr_q, ovr_d;
  logic      ack_q, ack_d;

  always_comb begin
    st_d    = st_q;
    seen_d  = seen_q;
    setup_d = setup_q;
    ovr_d   = ovr_q;
    ack_d   = 1'b0;
    fifo_wr = 1'b0;
    arm_clr = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (tok_valid) begin
          case (tok_kind)
            TOK_SETUP: begin
              if (ign_setup) begin
                st_d = ST_DROPS;
              end else if (seen_q) begin
                st_d = ST_DROPA;
              end else begin
                st_d    = ST_TAKE;
                setup_d = 1'b1;
                ovr_d   = 1'b0;
              end
            end
            TOK_OUT: begin
              seen_d = 1'b0;
              if (stall_in) begin
                arm_clr = 1'b1;
                st_d    = ST_DROPS;
              end else if (arm) begin
                st_d    = ST_TAKE;
                setup_d = 1'b0;
                ovr_d   = 1'b0;
              end else begin
                st_d = ST_DROPS;
              end
            end
            default: seen_d = 1'b0;
          endcase
        end
      end
      ST_TAKE: begin
        if (byte_valid) begin
          if (fifo_full) ovr_d   = 1'b1;
          else           fifo_wr = 1'b1;
        end
        if (pkt_end) begin
          st_d    = ST_IDLE;
          arm_clr = 1'b1;
          ack_d   = pkt_ok && !ovr_d;
          if (setup_q && ack_d) seen_d = 1'b1;
        end
      end
      ST_DROPA: begin
        if (pkt_end) begin
          st_d  = ST_IDLE;
          ack_d = pkt_ok;
        end
      end
      ST_DROPS: begin
        if (pkt_end) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      seen_q  <= 1'b0;
      setup_q <= 1'b0;
      ovr_q   <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      seen_q  <= seen_d;
      setup_q <= setup_d;
      ovr_q   <= ovr_d;
      ack_q   <= ack_d;
    end
  end

  assign idle     = (st_q == ST_IDLE);
  assign flush_go = flush_pend && idle;
  assign ack      = ack_q;

endmodule

// File: rtl/usb_rxep_warn.sv
module usb_rxep_warn
  import usb_rxep_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    wl_code,
  input  logic [LW-1:0] level,
  output logic          pulse
);

  logic [LW:0] room;
  logic [LW:0] limit;
  logic        cond, cond_q;

  always_comb begin
    room  = (LW + 1)'(DEPTH) - {1'b0, level};
    limit = (LW + 1)'(warn_room(wl_code));
    cond  = (wl_code != 2'b00) && (room <= limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond;
  end

  assign pulse = cond && !cond_q;

endmodule

// File: rtl/usb_rx_ep_ctrl.sv
module usb_rx_ep_ctrl
  import usb_rxep_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [7:0]    reg_wr_data,
  output logic [7:0]    reg_rd_data,
  input  logic          tok_valid,
  input  logic [1:0]    tok_kind,
  input  logic          stall_in,
  input  logic          rx_byte_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_pkt_end,
  input  logic          rx_pkt_ok,
  input  logic          fifo_rd_en,
  output logic [7:0]    fifo_rd_data,
  output logic [LW-1:0] fifo_level,
  output logic          hs_ack,
  output logic          warn_pulse
);

  logic [1:0] rs_q;
  logic       srst_n;
  logic       arm, ign_setup, flush_pend, arm_clr;
  logic [1:0] wl_code;
  logic       fifo_wr, fifo_full, flush_go, ep_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  usb_rxep_regs u_regs (
    .clk        (clk),
    .rst_n      (srst_n),
    .wr_en      (reg_wr_en),
    .wr_data    (reg_wr_data),
    .arm_clr    (arm_clr),
    .flush_done (flush_go),
    .arm        (arm),
    .ign_setup  (ign_setup),
    .wl_code    (wl_code),
    .flush_pend (flush_pend),
    .rd_data    (reg_rd_data)
  );

  usb_rxep_seq u_seq (
    .clk        (clk),
    .rst_n      (srst_n),
    .tok_valid  (tok_valid),
    .tok_kind   (tok_kind),
    .stall_in   (stall_in),
    .byte_valid (rx_byte_valid),
    .pkt_end    (rx_pkt_end),
    .pkt_ok     (rx_pkt_ok),
    .arm        (arm),
    .ign_setup  (ign_setup),
    .fifo_full  (fifo_full),
    .flush_pend (flush_pend),
    .fifo_wr    (fifo_wr),
    .arm_clr    (arm_clr),
    .flush_go   (flush_go),
    .idle       (ep_idle),
    .ack        (hs_ack)
  );

  usb_rxep_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk     (clk),
    .rst_n   (srst_n),
    .flush   (flush_go),
    .wr_en   (fifo_wr),
    .wr_data (rx_byte),
    .rd_en   (fifo_rd_en),
    .rd_data (fifo_rd_data),
    .level   (fifo_level),
    .full    (fifo_full)
  );

  usb_rxep_warn #(.DEPTH(DEPTH)) u_warn (
    .clk     (clk),
    .rst_n   (srst_n),
    .wl_code (wl_code),
    .level   (fifo_level),
    .pulse   (warn_pulse)
  );

endmodule

// File: rtl/usb_rxep_chk.sv
module usb_rxep_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          srst_n,
  input logic          reg_wr_en,
  input logic [7:0]    reg_rd_data,
  input logic          tok_valid,
  input logic [1:0]    tok_kind,
  input logic          stall_in,
  input logic          rx_pkt_end,
  input logic          rx_pkt_ok,
  input logic [LW-1:0] fifo_level,
  input logic          hs_ack,
  input logic          warn_pulse,
  input logic          ep_idle,
  input logic          flush_go
);

  // R3: the ACK request lasts one cycle
  p_ack_single_r3: assert property (@(posedge clk) disable iff (!srst_n)
    hs_ack |=> !hs_ack);

  // R9: an ACK needs a packet end without media error one cycle earlier
  p_ack_needs_ok_r9: assert property (@(posedge clk) disable iff (!srst_n)
    hs_ack |-> $past(rx_pkt_end && rx_pkt_ok));

  // R12: the warning is a single-cycle event
  p_warn_single_r12: assert property (@(posedge clk) disable iff (!srst_n)
    warn_pulse |=> !warn_pulse);

  // R10: the level never exceeds the depth
  p_level_cap_r10: assert property (@(posedge clk) disable iff (!srst_n)
    fifo_level <= LW'(DEPTH));

  // R11: an applied flush leaves the FIFO empty
  p_flush_empty_r11: assert property (@(posedge clk) disable iff (!srst_n)
    flush_go |=> (fifo_level == '0));

  // R5: a stalled OUT token disarms the endpoint
  p_stall_disarm_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (ep_idle && tok_valid && tok_kind == 2'b00 && stall_in && !reg_wr_en)
      |=> !reg_rd_data[0]);

endmodule

bind usb_rx_ep_ctrl usb_rxep_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .srst_n      (srst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_rd_data (reg_rd_data),
  .tok_valid   (tok_valid),
  .tok_kind    (tok_kind),
  .stall_in    (stall_in),
  .rx_pkt_end  (rx_pkt_end),
  .rx_pkt_ok   (rx_pkt_ok),
  .fifo_level  (fifo_level),
  .hs_ack      (hs_ack),
  .warn_pulse  (warn_pulse),
  .ep_idle     (ep_idle),
  .flush_go    (flush_go)
);

// File: tb/usb_rx_ep_ctrl_test.sv
`timescale 1ns/1ps
module usb_rx_ep_ctrl_test;

  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = 8'h00;
  logic [7:0] reg_rd_data;
  logic       tok_valid = 1'b0;
  logic [1:0] tok_kind = 2'b00;
  logic       stall_in = 1'b0;
  logic       rx_byte_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       rx_pkt_end = 1'b0;
  logic       rx_pkt_ok = 1'b0;
  logic       fifo_rd_en = 1'b0;
  logic [7:0] fifo_rd_data;
  logic [6:0] fifo_level;
  logic       hs_ack;
  logic       warn_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_rx_ep_ctrl #(.DEPTH(DEPTH)) uut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] v);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_data = v;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic send_pkt(input logic [1:0] kind, input int n, input int base,
                          input bit ok, input bit stall, input int wlim,
                          input bit chkw, output int acked, output int pulses);
    pulses = 0;
    @(negedge clk);
    tok_valid = 1'b1; tok_kind = kind; stall_in = stall;
    @(negedge clk);
    tok_valid = 1'b0; stall_in = 1'b0;
    for (int i = 0; i < n; i++) begin
      rx_byte_valid = 1'b1; rx_byte = 8'(base + i);
      @(negedge clk);
      if (warn_pulse) pulses++;
      if (chkw)
        check("R12 warn at byte", int'(warn_pulse),
              int'(wlim != 0 && (DEPTH - (i + 1)) == wlim));
    end
    rx_byte_valid = 1'b0;
    rx_pkt_end = 1'b1; rx_pkt_ok = ok;
    @(negedge clk);
    rx_pkt_end = 1'b0; rx_pkt_ok = 1'b0;
    acked = int'(hs_ack);
    @(negedge clk);
    check("R3 ack one cycle", int'(hs_ack), 0);
  endtask

  task automatic drain(input int n, input int base, input string req);
    for (int i = 0; i < n; i++) begin
      check(req, int'(fifo_rd_data), (base + i) & 8'hFF);
      fifo_rd_en = 1'b1;
      @(negedge clk);
      fifo_rd_en = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int ack, pl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 reg", int'(reg_rd_data), 0);
    check("R1 level", int'(fifo_level), 0);
    check("R1 ack", int'(hs_ack), 0);
    check("R1 warn", int'(warn_pulse), 0);

    // R2 layout
    wr_reg(8'hFF);
    check("R2 readback", int'(reg_rd_data), 8'h65);
    wr_reg(8'h00);
    check("R2 clear", int'(reg_rd_data), 0);

    // R4 unarmed OUT
    send_pkt(2'b00, 3, 8'h01, 1, 0, 0, 0, ack, pl);
    check("R4 no ack", ack, 0);
    check("R4 level", int'(fifo_level), 0);

    // R3 armed OUT, R13 read order
    wr_reg(8'h01);
    send_pkt(2'b00, 5, 8'h10, 1, 0, 0, 0, ack, pl);
    check("R3 ack", ack, 1);
    check("R3 level", int'(fifo_level), 5);
    check("R3 disarmed", int'(reg_rd_data), 0);
    drain(5, 8'h10, "R13 data");
    check("R13 level after drain", int'(fifo_level), 0);

    // R9 bad packet
    wr_reg(8'h01);
    send_pkt(2'b00, 2, 8'h20, 0, 0, 0, 0, ack, pl);
    check("R9 no ack", ack, 0);
    check("R9 bytes kept", int'(fifo_level), 2);
    check("R9 disarmed", int'(reg_rd_data), 0);
    wr_reg(8'h08);
    @(negedge clk);
    check("R11 idle flush", int'(fifo_level), 0);

    // R5 stall
    wr_reg(8'h01);
    send_pkt(2'b00, 2, 8'h30, 1, 1, 0, 0, ack, pl);
    check("R5 no ack", ack, 0);
    check("R5 level", int'(fifo_level), 0);
    check("R5 disarmed", int'(reg_rd_data), 0);

    // R6 / R8 SETUP handling
    wr_reg(8'h00);
    send_pkt(2'b01, 8, 8'h40, 1, 0, 0, 0, ack, pl);
    check("R6 ack", ack, 1);
    check("R6 level", int'(fifo_level), 8);
    send_pkt(2'b01, 8, 8'h50, 1, 0, 0, 0, ack, pl);
    check("R8 dup ack", ack, 1);
    check("R8 dup dropped", int'(fifo_level), 8);
    send_pkt(2'b00, 0, 0, 1, 0, 0, 0, ack, pl);
    check("R4 zero-length unarmed", ack, 0);
    send_pkt(2'b01, 8, 8'h60, 1, 0, 0, 0, ack, pl);
    check("R8 new setup ack", ack, 1);
    check("R8 new setup stored", int'(fifo_level), 16);
    drain(8, 8'h40, "R8 first setup data");
    drain(8, 8'h60, "R8 third setup data");

    // R7 ignore SETUP, even right after an accepted one
    wr_reg(8'h04);
    send_pkt(2'b01, 4, 8'h70, 1, 0, 0, 0, ack, pl);
    check("R7 no ack", ack, 0);
    check("R7 level", int'(fifo_level), 0);
    wr_reg(8'h00);

    // R11 deferred flush
    wr_reg(8'h01);
    @(negedge clk);
    tok_valid = 1'b1; tok_kind = 2'b00;
    @(negedge clk);
    tok_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      rx_byte_valid = 1'b1; rx_byte = 8'(8'h80 + i);
      @(negedge clk);
    end
    rx_byte_valid = 1'b0;
    reg_wr_en = 1'b1; reg_wr_data = 8'h08;
    @(negedge clk);
    reg_wr_en = 1'b0;
    for (int i = 3; i < 5; i++) begin
      rx_byte_valid = 1'b1; rx_byte = 8'(8'h80 + i);
      @(negedge clk);
    end
    rx_byte_valid = 1'b0;
    check("R11 deferred keeps data", int'(fifo_level), 5);
    rx_pkt_end = 1'b1; rx_pkt_ok = 1'b1;
    @(negedge clk);
    rx_pkt_end = 1'b0; rx_pkt_ok = 1'b0;
    check("R11 ack during pending flush", int'(hs_ack), 1);
    check("R11 not flushed at end", int'(fifo_level), 5);
    @(negedge clk);
    check("R11 flushed after end", int'(fifo_level), 0);

    // R10 overrun
    wr_reg(8'h01);
    send_pkt(2'b00, DEPTH + 1, 0, 1, 0, 0, 0, ack, pl);
    check("R10 no ack", ack, 0);
    check("R10 level", int'(fifo_level), DEPTH);
    check("R12 disabled no pulse", pl, 0);
    drain(DEPTH, 0, "R10 data");

    // R12 sweep of limit codes
    for (int c = 1; c < 4; c++) begin
      int lim;
      lim = (c == 1) ? 4 : (c == 2) ? 8 : 16;
      wr_reg(8'((c << 5) | 1));
      send_pkt(2'b00, DEPTH, 8'h90, 1, 0, lim, 1, ack, pl);
      check("R12 pulse count", pl, 1);
      check("R3 full packet ack", ack, 1);
      wr_reg(8'((c << 5) | 8));
      @(negedge clk);
      check("R11 flush after sweep", int'(fifo_level), 0);
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule